// File: doc/BRIEF.md
# Histogram Channel Store

This block holds a bank of counters, each as wide as a data word, and serves as a histogram store. A command controller drives it through a single request port. Each request carries an operation code, a channel address and a data word. The store accepts six operations:

- write a word to a channel;
- read a word back from a channel;
- add one to a channel, as a read-modify-write;
- zero every channel;
- start acquisition;
- stop acquisition.

The acquisition flag is kept here and reported to the controller, which uses it to decide when event increments should be issued.

When a channel reaches the all-ones terminal count, a sticky overflow flag is raised. Only a completed full clear lowers it again. A channel already at the terminal count stays there rather than wrapping, so no recorded histogram is corrupted.

The increment and the clear take more than one cycle. During them the store raises `busy` and drops every request that arrives. A separate holding register captures the most recent conversion value whenever its load strobe is high.

Top module: `hist_store`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `rd_valid`, `acq_active`, `ovf_flag` and `last_conv` are all 0.
- R2: A request is accepted on a rising clock edge where `req_valid` is 1 and `busy` is 0. Operation code 0 stores `req_wdata` at `req_addr`. Code 1 raises `rd_valid` for exactly the one cycle after acceptance, with `rd_data` holding the word stored at `req_addr`.
- R3: Code 2 adds one to the word at `req_addr`. `busy` is 1 for exactly the one cycle after acceptance, and the new value can be read once `busy` is 0.
- R4: A request presented while `busy` is 1 has no effect on memory contents, `rd_valid`, `acq_active` or `ovf_flag`.
- R5: Code 3 zeroes all DEPTH channels, one per cycle. `busy` is 1 for exactly DEPTH cycles after acceptance.
- R6: An increment of a channel that holds 65535 (all ones) leaves it at 65535.
- R7: Code 4 sets `acq_active` from the cycle after acceptance, and code 5 clears it. Codes 6 and 7 change neither memory nor any output.
- R8: `ovf_flag` rises in the cycle after an increment's write-back that leaves the channel at 65535, including the saturated case. A direct write of 65535 does not raise it. Once raised, it holds through writes, reads, increments, start and stop.
- R9: `ovf_flag` falls only when a clear completes, being 0 from the same cycle in which `busy` returns to 0 after that clear.
- R10: `last_conv` takes `conv_data` on every edge where `conv_load` is 1, whether or not `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code (0 write, 1 read, 2 increment, 3 clear, 4 start, 5 stop) |
| req_addr | input | AW | Channel address |
| req_wdata | input | DW | Data for a write |
| busy | output | 1 | Multi-cycle operation in progress; requests are dropped |
| rd_valid | output | 1 | `rd_data` holds a read result |
| rd_data | output | DW | Read result |
| acq_active | output | 1 | Acquisition armed |
| ovf_flag | output | 1 | Sticky terminal-count flag |
| conv_load | input | 1 | Capture strobe for the conversion register |
| conv_data | input | DW | Most recent conversion value |
| last_conv | output | DW | Held conversion value |

## Verification
The bench builds the store with DEPTH = 16 and a 16-bit word. The shallow memory makes a full clear last only sixteen cycles, so the bench can check the exact busy length and confirm that every channel reads zero afterwards. The 16-bit width is kept so that the real terminal count of 65535 is reached: a channel is preloaded to 65534 and incremented through the edge and beyond it.

// File: rtl/hist_pkg.sv
// Package: shared operation codes and write-data selectors for the
// histogram store. Assumes a 3-bit operation field on the request port.
package hist_pkg;

    typedef enum logic [2:0] {
        OP_WRITE = 3'd0,
        OP_READ  = 3'd1,
        OP_INCR  = 3'd2,
        OP_CLEAR = 3'd3,
        OP_START = 3'd4,
        OP_STOP  = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        WSEL_HOST = 2'd0,
        WSEL_INCR = 2'd1,
        WSEL_ZERO = 2'd2
    } wsel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INCR = 2'd1,
        ST_CLR  = 2'd2
    } state_e;

endpackage

// File: rtl/hist_mem.sv
// Module: single-port-write / registered-read counter array.
// Assumes addresses are below DEPTH; contents are not reset (a clear
// command is the way to zero them). The read register is reset.
module hist_mem #(
    parameter int DW    = 16,
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] store [DEPTH];

    // Write port: one word per cycle when enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Read port: capture the addressed word into the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= store[raddr];
        end
    end

endmodule

// File: rtl/hist_incr.sv
// Module: next-value logic for a channel increment. SATURATE selects
// holding at all-ones (1) or wrapping (0). Flags a result at all-ones.
module hist_incr #(
    parameter int DW       = 16,
    parameter bit SATURATE = 1'b1
) (
    input  logic [DW-1:0] cur,
    output logic [DW-1:0] nxt,
    output logic          at_top
);

    localparam logic [DW-1:0] TOP = {DW{1'b1}};

    generate
        if (SATURATE) begin : g_sat
            // Hold at the terminal count instead of rolling over.
            always_comb nxt = (cur == TOP) ? TOP : cur + 1'b1;
        end else begin : g_wrap
            // Plain modulo increment.
            always_comb nxt = cur + 1'b1;
        end
    endgenerate

    // Terminal-count detection on the value to be written back.
    always_comb at_top = (nxt == TOP);

endmodule

// File: rtl/hist_ctrl.sv
// Module: request sequencer. Accepts one request when idle, runs the
// two-cycle increment and the DEPTH-cycle clear, and keeps the
// acquisition and overflow flags. Assumes requests are single-cycle
// pulses qualified by req_valid; anything arriving while busy is dropped.
module hist_ctrl
    import hist_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic          at_top,
    output logic          busy,
    output logic          clr_run,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic          mem_re,
    output logic [AW-1:0] mem_raddr,
    output wsel_e         wsel,
    output logic          rd_valid,
    output logic          acq_active,
    output logic          ovf_flag
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    state_e        state;
    logic [AW-1:0] hold_addr;
    logic [AW-1:0] clr_idx;
    logic          accept;
    op_e           op;

    always_comb op      = op_e'(req_op);
    always_comb accept  = req_valid && (state == ST_IDLE);
    always_comb busy    = (state != ST_IDLE);
    always_comb clr_run = (state == ST_CLR);

    // Memory port steering for the current state and request.
    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = req_addr;
        mem_re    = 1'b0;
        mem_raddr = req_addr;
        wsel      = WSEL_HOST;
        unique case (state)
            ST_INCR: begin
                mem_we    = 1'b1;
                mem_waddr = hold_addr;
                wsel      = WSEL_INCR;
            end
            ST_CLR: begin
                mem_we    = 1'b1;
                mem_waddr = clr_idx;
                wsel      = WSEL_ZERO;
            end
            default: begin
                if (accept) begin
                    mem_we = (op == OP_WRITE);
                    mem_re = (op == OP_READ) || (op == OP_INCR);
                end
            end
        endcase
    end

    // Sequencer state, held increment address and clear index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            hold_addr <= '0;
            clr_idx   <= '0;
        end else begin
            unique case (state)
                ST_INCR: state <= ST_IDLE;
                ST_CLR: begin
                    clr_idx <= clr_idx + 1'b1;
                    if (clr_idx == LAST) begin
                        state <= ST_IDLE;
                    end
                end
                default: begin
                    if (accept && op == OP_INCR) begin
                        state     <= ST_INCR;
                        hold_addr <= req_addr;
                    end else if (accept && op == OP_CLEAR) begin
                        state   <= ST_CLR;
                        clr_idx <= '0;
                    end
                end
            endcase
        end
    end

    // Read-response strobe, one cycle after an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= accept && (op == OP_READ);
        end
    end

    // Acquisition arm/disarm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acq_active <= 1'b0;
        end else if (accept && op == OP_START) begin
            acq_active <= 1'b1;
        end else if (accept && op == OP_STOP) begin
            acq_active <= 1'b0;
        end
    end

    // Sticky overflow: set on a terminal write-back, cleared at clear end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (state == ST_INCR && at_top) begin
            ovf_flag <= 1'b1;
        end else if (state == ST_CLR && clr_idx == LAST) begin
            ovf_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/hist_store.sv
// Module: top of the histogram store. Joins the sequencer, the counter
// array and the increment logic, and holds the conversion register.
// Assumes req_addr < DEPTH and a synchronous active-low reset.
module hist_store
    import hist_pkg::*;
#(
    parameter int DW       = 16,
    parameter int DEPTH    = 1024,
    parameter bit SATURATE = 1'b1,
    parameter int AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          busy,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          acq_active,
    output logic          ovf_flag,
    input  logic          conv_load,
    input  logic [DW-1:0] conv_data,
    output logic [DW-1:0] last_conv
);

    logic          clr_run;
    logic          mem_we;
    logic          mem_re;
    logic [AW-1:0] mem_waddr;
    logic [AW-1:0] mem_raddr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] inc_val;
    logic          at_top;
    wsel_e         wsel;

    hist_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_addr   (req_addr),
        .at_top     (at_top),
        .busy       (busy),
        .clr_run    (clr_run),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_re     (mem_re),
        .mem_raddr  (mem_raddr),
        .wsel       (wsel),
        .rd_valid   (rd_valid),
        .acq_active (acq_active),
        .ovf_flag   (ovf_flag)
    );

    hist_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .re    (mem_re),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    hist_incr #(.DW(DW), .SATURATE(SATURATE)) u_incr (
        .cur    (mem_rdata),
        .nxt    (inc_val),
        .at_top (at_top)
    );

    // Write-data source for the array.
    always_comb begin
        unique case (wsel)
            WSEL_INCR: mem_wdata = inc_val;
            WSEL_ZERO: mem_wdata = '0;
            default:   mem_wdata = req_wdata;
        endcase
    end

    always_comb rd_data = mem_rdata;

    // Conversion holding register, loaded on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_conv <= '0;
        end else if (conv_load) begin
            last_conv <= conv_data;
        end
    end

endmodule

// File: rtl/hist_store_chk.sv
// Module: protocol checker bound to hist_store. Observes ports and the
// clear-in-progress signal; drives nothing.
module hist_store_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [2:0] req_op,
    input logic       busy,
    input logic       clr_run,
    input logic       rd_valid,
    input logic       acq_active,
    input logic       ovf_flag
);

    logic taken;
    always_comb taken = req_valid && !busy;

    assert_read_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(taken && req_op == 3'd1));

    assert_read_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid || $past(taken && req_op == 3'd1));

    assert_incr_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && req_op == 3'd2) |=> busy);

    assert_incr_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && req_op == 3'd2) |-> ##2 !busy);

    assert_clear_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && req_op == 3'd3) |=> busy && clr_run);

    assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && req_op == 3'd4) |=> acq_active);

    assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && req_op == 3'd5) |=> !acq_active);

    assert_ovf_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(busy) && !$past(clr_run));

    assert_ovf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_run) |=> ovf_flag);

    assert_ovf_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_flag) |-> $past(clr_run) && !busy);

endmodule

bind hist_store hist_store_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .busy       (busy),
    .clr_run    (clr_run),
    .rd_valid   (rd_valid),
    .acq_active (acq_active),
    .ovf_flag   (ovf_flag)
);

// File: tb/tb_hist_store.sv
module tb_hist_store;

    localparam int DW    = 16;
    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int TOPV  = 65535;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          busy, rd_valid, acq_active, ovf_flag;
    logic [DW-1:0] rd_data, last_conv;
    logic          conv_load = 1'b0;
    logic [DW-1:0] conv_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    hist_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .acq_active(acq_active),
        .ovf_flag(ovf_flag), .conv_load(conv_load), .conv_data(conv_data),
        .last_conv(last_conv)
    );

    always #5 clk = ~clk;

    // Behavioural reference model, advanced on every rising edge.
    int m_mem [DEPTH];
    bit m_inc = 0, m_clr = 0, m_rdv = 0, m_acq = 0, m_ovf = 0;
    int m_iaddr = 0, m_cidx = 0, m_rdd = 0, m_conv = 0;
    bit started = 0;

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_inc = 0; m_clr = 0; m_rdv = 0; m_acq = 0; m_ovf = 0; m_conv = 0;
        end else begin
            m_rdv = 0;
            if (m_inc) begin
                int v;
                v = m_mem[m_iaddr];
                if (v < TOPV) v = v + 1;
                m_mem[m_iaddr] = v;
                if (v == TOPV) m_ovf = 1;
                m_inc = 0;
            end else if (m_clr) begin
                m_mem[m_cidx] = 0;
                m_cidx = m_cidx + 1;
                if (m_cidx == DEPTH) begin
                    m_clr = 0;
                    m_ovf = 0;
                end
            end else if (req_valid) begin
                case (req_op)
                    3'd0: m_mem[req_addr] = int'(req_wdata);
                    3'd1: begin m_rdv = 1; m_rdd = m_mem[req_addr]; end
                    3'd2: begin m_inc = 1; m_iaddr = int'(req_addr); end
                    3'd3: begin m_clr = 1; m_cidx = 0; end
                    3'd4: m_acq = 1;
                    3'd5: m_acq = 0;
                    default: ;
                endcase
            end
            if (conv_load) m_conv = int'(conv_data);
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            check("R3/R5 busy", int'(busy), int'(m_inc || m_clr));
            check("R2 rd_valid", int'(rd_valid), int'(m_rdv));
            if (m_rdv) check("R2 rd_data", int'(rd_data), m_rdd);
            check("R7 acq_active", int'(acq_active), int'(m_acq));
            check("R8/R9 ovf_flag", int'(ovf_flag), int'(m_ovf));
            check("R10 last_conv", int'(last_conv), m_conv);
        end
    end

    task automatic issue(input int op, input int addr, input int data);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = 3'(op);
        req_addr  = AW'(addr);
        req_wdata = DW'(data);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic read_expect(input string tag, input int addr, input int exp);
        issue(1, addr, 0);
        check(tag, int'(rd_valid), 1);
        check(tag, int'(rd_data), exp);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 rd_valid", int'(rd_valid), 0);
        check("R1 acq", int'(acq_active), 0);
        check("R1 ovf", int'(ovf_flag), 0);
        check("R1 conv", int'(last_conv), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", int'(busy | acq_active | ovf_flag | rd_valid), 0);

        // R5: clear length and contents; a write during clear is dropped (R4).
        issue(3, 0, 0);
        cyc = 1;
        req_valid = 1'b1; req_op = 3'd0; req_addr = 4'd9; req_wdata = 16'd77;
        @(negedge clk);
        req_valid = 1'b0;
        cyc++;
        while (busy) begin @(negedge clk); cyc++; end
        check("R5 busy cycles", cyc - 1, DEPTH);
        for (int a = 0; a < DEPTH; a++) read_expect("R5 zeroed", a, 0);

        // R2: writes and reads with distinct patterns.
        issue(0, 1, 16'h1234);
        issue(0, 15, 16'hFFFE);
        issue(0, 3, 10);
        read_expect("R2 read a1", 1, 16'h1234);
        read_expect("R2 read a15", 15, 16'hFFFE);

        // R3: two increments with exact busy window.
        issue(2, 3, 0);
        check("R3 busy high", int'(busy), 1);
        @(negedge clk);
        check("R3 busy low", int'(busy), 0);
        issue(2, 3, 0);
        wait_idle();
        read_expect("R3 incr twice", 3, 12);

        // R4: write presented during increment busy is ignored.
        issue(0, 5, 40);
        issue(2, 5, 0);
        req_valid = 1'b1; req_op = 3'd0; req_addr = 4'd5; req_wdata = 16'd999;
        @(negedge clk);
        req_valid = 1'b0;
        read_expect("R4 dropped write", 5, 41);

        // R7: start/stop and unused codes 6, 7.
        issue(4, 0, 0);
        check("R7 started", int'(acq_active), 1);
        issue(6, 1, 0);
        issue(7, 1, 0);
        check("R7 codes 6/7", int'(acq_active), 1);
        read_expect("R7 codes 6/7 memory", 1, 16'h1234);
        issue(5, 0, 0);
        check("R7 stopped", int'(acq_active), 0);

        // R8: direct write of terminal value does not flag.
        issue(0, 8, TOPV);
        check("R8 write no flag", int'(ovf_flag), 0);
        issue(0, 7, TOPV - 1);
        issue(2, 7, 0);
        @(negedge clk);
        check("R8 flag set", int'(ovf_flag), 1);
        // R6: saturated increment.
        issue(2, 7, 0);
        wait_idle();
        read_expect("R6 saturate", 7, TOPV);
        issue(2, 8, 0);
        wait_idle();
        read_expect("R6 saturate direct", 8, TOPV);
        issue(4, 0, 0);
        issue(5, 0, 0);
        issue(0, 2, 5);
        check("R8 sticky", int'(ovf_flag), 1);

        // R9 with R10: clear drops the flag as busy falls; conv loads during busy.
        issue(3, 0, 0);
        conv_load = 1'b1; conv_data = 16'hBEEF;
        @(negedge clk);
        conv_load = 1'b0;
        check("R10 load during busy", int'(last_conv), 16'hBEEF);
        while (busy) begin
            check("R9 flag held while clearing", int'(ovf_flag), 1);
            @(negedge clk);
        end
        check("R9 flag cleared", int'(ovf_flag), 0);
        read_expect("R5 second clear", 7, 0);
        read_expect("R4 clear-time write", 9, 0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule